// File: doc/BRIEF.md
# Inter-thread storage control port

This block sits between a simple memory-mapped request bus and an array of inter-thread communication cells. Each request carries an access view in address bits 6:3. The port sorts every request into one of four kinds: a cell access, a control register access, a sub-word bus error or an undefined view. A cell access is routed to exactly one cell through a one-hot strobe. The cell is chosen from the address using a stride set by a granularity field in the control register.

The control register holds three sticky error flags, a three-bit granularity field and a read-only cell count. Software reads it, clears flags with write-one-to-clear and reloads the granularity through view 15. The cell array reports execution and parity faults on two input pins. Empty/full and semaphore behaviour belongs to the cell array, not to this port.

Top module: `itc_ctl_port`

## Requirements
- R1: After reset the error flags and the granularity field are zero. Control register bits 16 and up hold NUM_CELLS. No cell strobe or response is active.
- R2: A request of 1 or 2 bytes becomes a bus error whatever its view. It returns rsp_buserr with read data 0, sets error bit 2 (interconnect) sticky, strobes no cell and changes no other control bit.
- R3: A 4- or 8-byte read with view 15 returns the whole control register: bits 2:0 flags, bits 10:8 granularity, count from bit 16.
- R4: A write with view 15 clears each of error bits 2:0 whose data bit is 1. Error bits written with 0 keep their value.
- R5: The same write loads data bits 10:8 into the granularity field. No other request changes the granularity, and the count is never writable.
- R6: Views 0, 2, 3, 4 and 5 are cell views. One cycle after such a request exactly one cell_sel bit is high, for index (addr >> (7 + granularity)) mod NUM_CELLS. cell_view, cell_we and cell_wdata carry the request in that same cycle.
- R7: A cell read returns the cell_rdata that the array presents while its strobe is high. A write response returns data 0.
- R8: Views 1 and 6 to 14 are undefined. A read returns all ones and a write changes nothing. Both raise rsp_badview for the response cycle, and no cell is strobed.
- R9: Every request gets exactly one rsp_valid pulse, two cycles after the request cycle.
- R10: A pulse on cell_err_exec sets error bit 0, and a pulse on cell_err_parity sets error bit 1. Both flags stay set until cleared. A set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address; bits 6:3 hold the view |
| req_bytes | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data |
| rsp_buserr | output | 1 | Bus error response |
| rsp_badview | output | 1 | Undefined view response |
| cell_sel | output | NUM_CELLS | One-hot cell strobe |
| cell_view | output | 4 | View passed to the cell |
| cell_we | output | 1 | Write flag passed to the cell |
| cell_wdata | output | DATA_W | Write data passed to the cell |
| cell_rdata | input | DATA_W | Data returned by the strobed cell |
| cell_err_exec | input | 1 | Execution fault from the cell array |
| cell_err_parity | input | 1 | Parity fault from the cell array |

## Verification
A wrong granularity value shows at the ports on the next cell access, one cycle later, as a strobe on the wrong cell, and on the next view 15 read. A lost or stuck error flag stays hidden until a control register read, so the bench reads the register after every write, fault pulse and bus error. A misclassified request shows in the cycle after it as a stray strobe, and one cycle after that as wrong read data or flags.

// File: rtl/itc_port_pkg.sv
package itc_port_pkg;
  localparam logic [3:0] VIEW_RAW     = 4'd0;
  localparam logic [3:0] VIEW_EF_WAIT = 4'd2;
  localparam logic [3:0] VIEW_EF_POLL = 4'd3;
  localparam logic [3:0] VIEW_PV_WAIT = 4'd4;
  localparam logic [3:0] VIEW_PV_POLL = 4'd5;
  localparam logic [3:0] VIEW_CTRL    = 4'd15;

  localparam int VIEW_LSB    = 3;
  localparam int VIEW_W      = 4;
  localparam int ERR_W       = 3;
  localparam int ERR_EXEC    = 0;
  localparam int ERR_PARITY  = 1;
  localparam int ERR_BUS     = 2;
  localparam int GRAIN_LSB   = 8;
  localparam int GRAIN_W     = 3;
  localparam int COUNT_LSB   = 16;
  localparam int STRIDE_BASE = 7;

  typedef enum logic [1:0] {
    ACC_CELL    = 2'd0,
    ACC_CTRL    = 2'd1,
    ACC_BUSERR  = 2'd2,
    ACC_BADVIEW = 2'd3
  } acc_kind_e;

  function automatic logic is_cell_view(input logic [3:0] v);
    return (v == VIEW_RAW) || (v == VIEW_EF_WAIT) || (v == VIEW_EF_POLL) ||
           (v == VIEW_PV_WAIT) || (v == VIEW_PV_POLL);
  endfunction
endpackage

// File: rtl/itc_view_decode.sv
module itc_view_decode
  import itc_port_pkg::*;
(
  input  logic [3:0]  bytes,
  input  logic [3:0]  view,
  output acc_kind_e   kind
);
  logic sub_word;
  assign sub_word = (bytes == 4'd1) || (bytes == 4'd2);

  always_comb begin
    if (sub_word)                kind = ACC_BUSERR;
    else if (view == VIEW_CTRL)  kind = ACC_CTRL;
    else if (is_cell_view(view)) kind = ACC_CELL;
    else                         kind = ACC_BADVIEW;
  end
endmodule

// File: rtl/itc_ctrl_reg.sv
module itc_ctrl_reg
  import itc_port_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NUM_CELLS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                set_bus,
  input  logic                set_exec,
  input  logic                set_parity,
  output logic [DATA_W-1:0]   ctrl_word,
  output logic [GRAIN_W-1:0]  grain
);
  localparam int CNT_W = $clog2(NUM_CELLS + 1);

  logic [ERR_W-1:0]   err_q, err_clr, err_set;
  logic [GRAIN_W-1:0] grain_q;

  always_comb begin
    err_clr = wr_en ? wdata[ERR_W-1:0] : '0;
    err_set = '0;
    err_set[ERR_BUS]    = set_bus;
    err_set[ERR_EXEC]   = set_exec;
    err_set[ERR_PARITY] = set_parity;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      grain_q <= '0;
    end else begin
      err_q <= (err_q & ~err_clr) | err_set;
      if (wr_en) grain_q <= wdata[GRAIN_LSB +: GRAIN_W];
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[ERR_W-1:0] = err_q;
    ctrl_word[GRAIN_LSB +: GRAIN_W] = grain_q;
    ctrl_word[COUNT_LSB +: CNT_W] = CNT_W'(NUM_CELLS);
  end
  assign grain = grain_q;

  p_sticky_bus_r2: assert property (@(posedge clk) disable iff (rst)
    set_bus |=> err_q[ERR_BUS]);
  p_w1c_exec_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[ERR_EXEC] && !set_exec) |=> !err_q[ERR_EXEC]);
  p_zero_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (err_q[ERR_PARITY] && !(wr_en && wdata[ERR_PARITY])) |=> err_q[ERR_PARITY]);
  p_grain_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(grain_q));
  p_grain_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> grain_q == $past(wdata[GRAIN_LSB +: GRAIN_W]));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_exec |=> err_q[ERR_EXEC]);
endmodule

// File: rtl/itc_cell_index.sv
module itc_cell_index
  import itc_port_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int NUM_CELLS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [GRAIN_W-1:0]   grain,
  output logic [NUM_CELLS-1:0] sel
);
  localparam int IDX_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;

  logic [ADDR_W-1:0]    shifted;
  logic [IDX_W-1:0]     idx;
  logic [NUM_CELLS-1:0] sel_d, sel_q;

  assign shifted = addr >> (STRIDE_BASE + int'(grain));
  assign idx     = shifted[IDX_W-1:0];

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_dec
    assign sel_d[g] = fire && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_d;
  end
  assign sel = sel_q;

  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));
  p_fire_hits_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> $countones(sel_q) == 1);
endmodule

// File: rtl/itc_ctl_port.sv
module itc_ctl_port
  import itc_port_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 64,
  parameter int NUM_CELLS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [3:0]           req_bytes,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_buserr,
  output logic                 rsp_badview,
  output logic [NUM_CELLS-1:0] cell_sel,
  output logic [3:0]           cell_view,
  output logic                 cell_we,
  output logic [DATA_W-1:0]    cell_wdata,
  input  logic [DATA_W-1:0]    cell_rdata,
  input  logic                 cell_err_exec,
  input  logic                 cell_err_parity
);
  acc_kind_e            kind, s1_kind;
  logic [VIEW_W-1:0]    view;
  logic [DATA_W-1:0]    ctrl_word, s1_snap;
  logic [GRAIN_W-1:0]   grain;
  logic                 s1_valid, s1_write;
  logic                 ctrl_wr, bus_hit, cell_fire;

  assign view      = req_addr[VIEW_LSB +: VIEW_W];
  assign ctrl_wr   = req_valid && req_write && (kind == ACC_CTRL);
  assign bus_hit   = req_valid && (kind == ACC_BUSERR);
  assign cell_fire = req_valid && (kind == ACC_CELL);

  itc_view_decode u_dec (
    .bytes (req_bytes),
    .view  (view),
    .kind  (kind)
  );

  itc_ctrl_reg #(.DATA_W(DATA_W), .NUM_CELLS(NUM_CELLS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctrl_wr),
    .wdata      (req_wdata),
    .set_bus    (bus_hit),
    .set_exec   (cell_err_exec),
    .set_parity (cell_err_parity),
    .ctrl_word  (ctrl_word),
    .grain      (grain)
  );

  itc_cell_index #(.ADDR_W(ADDR_W), .NUM_CELLS(NUM_CELLS)) u_idx (
    .clk   (clk),
    .rst   (rst),
    .fire  (cell_fire),
    .addr  (req_addr),
    .grain (grain),
    .sel   (cell_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_kind    <= ACC_CELL;
      s1_write   <= 1'b0;
      s1_snap    <= '0;
      cell_view  <= '0;
      cell_we    <= 1'b0;
      cell_wdata <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_kind    <= kind;
        s1_write   <= req_write;
        s1_snap    <= ctrl_word;
        cell_view  <= view;
        cell_we    <= req_write && (kind == ACC_CELL);
        cell_wdata <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_buserr  <= 1'b0;
      rsp_badview <= 1'b0;
    end else begin
      rsp_valid   <= s1_valid;
      rsp_buserr  <= s1_valid && (s1_kind == ACC_BUSERR);
      rsp_badview <= s1_valid && (s1_kind == ACC_BADVIEW);
      rsp_rdata   <= '0;
      if (s1_valid && !s1_write) begin
        case (s1_kind)
          ACC_CELL:    rsp_rdata <= cell_rdata;
          ACC_CTRL:    rsp_rdata <= s1_snap;
          ACC_BADVIEW: rsp_rdata <= '1;
          default:     rsp_rdata <= '0;
        endcase
      end
    end
  end

  p_one_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> rsp_valid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !rsp_valid);
  p_buserr_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    bus_hit |=> cell_sel == '0);
  p_badview_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == ACC_BADVIEW) |=> cell_sel == '0);
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_badview |-> !rsp_buserr);
endmodule

// File: tb/sim_itc_ctl_port.sv
module sim_itc_ctl_port;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 64;
  localparam int NCELL  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_bytes = 4'd8;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid, rsp_buserr, rsp_badview;
  logic [DATA_W-1:0] rsp_rdata, cell_wdata, cell_rdata;
  logic [NCELL-1:0]  cell_sel;
  logic [3:0]        cell_view;
  logic              cell_we;
  logic              err_exec = 1'b0, err_par = 1'b0;

  int total = 0, bad = 0;
  logic [2:0] m_err = '0;
  logic [2:0] m_grain = '0;

  always #2 clk = ~clk;

  itc_ctl_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CELLS(NCELL)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_buserr(rsp_buserr),
    .rsp_badview(rsp_badview), .cell_sel(cell_sel), .cell_view(cell_view),
    .cell_we(cell_we), .cell_wdata(cell_wdata), .cell_rdata(cell_rdata),
    .cell_err_exec(err_exec), .cell_err_parity(err_par));

  function automatic logic [DATA_W-1:0] stub_data(input int idx, input logic [3:0] v);
    return 64'hC0DE_0000_0000_0000 | (DATA_W'(idx) << 8) | DATA_W'(v);
  endfunction

  always_comb begin
    cell_rdata = '0;
    for (int i = 0; i < NCELL; i++)
      if (cell_sel[i]) cell_rdata = stub_data(i, cell_view);
  end

  function automatic logic [DATA_W-1:0] exp_ctrl();
    return (DATA_W'(NCELL) << 16) | (DATA_W'(m_grain) << 8) | DATA_W'(m_err);
  endfunction

  function automatic bit view_cell(input logic [3:0] v);
    return v == 0 || v == 2 || v == 3 || v == 4 || v == 5;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [3:0] nb, input logic [DATA_W-1:0] wd);
    logic [3:0] v;
    bit sub, ctl, cel;
    int idx;
    logic [DATA_W-1:0] exp_rd;
    v   = a[6:3];
    sub = (nb == 1) || (nb == 2);
    ctl = !sub && v == 4'd15;
    cel = !sub && view_cell(v);
    idx = int'((a >> (7 + m_grain)) & (NCELL - 1));
    exp_rd = '0;
    if (!wr) begin
      if (ctl) exp_rd = exp_ctrl();
      else if (cel) exp_rd = stub_data(idx, v);
      else if (!sub) exp_rd = '1;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_bytes = nb; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 no early response", DATA_W'(rsp_valid), 0);
    if (cel) begin
      check("R6 cell strobe", DATA_W'(cell_sel), DATA_W'(NCELL'(1) << idx));
      check("R6 cell view/we", {59'd0, cell_we, cell_view}, {59'd0, wr, v});
      if (wr) check("R6 cell wdata", cell_wdata, wd);
    end else begin
      check(sub ? "R2 no strobe on bus error" : (ctl ? "R3 no strobe" : "R8 no strobe"),
            DATA_W'(cell_sel), 0);
    end
    if (sub) m_err[2] = 1'b1;
    else if (ctl && wr) begin
      m_err   = m_err & ~wd[2:0];
      m_grain = wd[10:8];
    end
    @(negedge clk);
    check("R9 response pulse", DATA_W'(rsp_valid), 1);
    check(sub ? "R2 buserr flag" : "R2 no buserr", DATA_W'(rsp_buserr), DATA_W'(sub));
    check("R8 badview flag", DATA_W'(rsp_badview), DATA_W'(!sub && !ctl && !cel));
    check(sub ? "R2 read data" : (ctl ? "R3 ctrl read" : (cel ? "R7 cell read" : "R8 read ones")),
          rsp_rdata, exp_rd);
  endtask

  task automatic read_ctrl(input string req);
    logic [DATA_W-1:0] e;
    e = exp_ctrl();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h78; req_bytes = 4'd8;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(req, rsp_rdata, e);
  endtask

  task automatic fault(input bit e, input bit p);
    @(negedge clk);
    err_exec = e; err_par = p;
    @(negedge clk);
    err_exec = 1'b0; err_par = 1'b0;
    if (e) m_err[0] = 1'b1;
    if (p) m_err[1] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle strobes", DATA_W'(cell_sel), 0);
    check("R1 idle response", DATA_W'(rsp_valid), 0);
    read_ctrl("R1 reset control value");

    // R2: sub-word write to view 15 must not load granularity
    access(1'b1, 24'h78, 4'd1, 64'h0000_0700);
    read_ctrl("R2 sticky bit 2, grain unchanged");
    access(1'b0, 24'h10, 4'd2, '0);

    // R10: faults set flags; R4: W1C partial clear
    fault(1'b1, 1'b1);
    read_ctrl("R10 fault flags set");
    access(1'b1, 24'h78, 4'd8, 64'h0000_0305);
    read_ctrl("R4 W1C leaves bit 1, R5 grain=3");

    // R6 / R7 at several granularities
    for (int g = 0; g < 8; g += 3) begin
      access(1'b1, 24'h78, 4'd4, DATA_W'(g) << 8);
      access(1'b0, 24'h00_0A10 << g, 4'd8, '0);
      access(1'b1, (24'h00_0380 << g) | 24'h28, 4'd8, 64'h1234_5678_9ABC_DEF0);
    end

    // R8: undefined views
    access(1'b0, 24'h08, 4'd8, '0);
    access(1'b1, 24'h30, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF);
    read_ctrl("R8 write to bad view ignored");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a;
      logic [3:0] nb;
      logic [DATA_W-1:0] wd;
      a  = ADDR_W'($urandom);
      nb = 4'(1 << ($urandom % 4));
      wd = {$urandom, $urandom};
      if (($urandom % 4) == 0) a[6:3] = 4'd15;
      if (($urandom % 16) == 0) fault(1'($urandom), 1'($urandom));
      access(1'($urandom), a, nb, wd);
      if ((n % 25) == 0) read_ctrl("R4 R5 control after random mix");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule